// File: doc/BRIEF.md
# Dual-Core Doorbell Interrupt Unit

This peripheral lets two processor cores interrupt each other through a small set of memory-mapped registers in a 4 KB window. Each core owns a 4-bit pending word. The other core, or the same one, sets bits by writing ones to a set register and removes them by writing ones to a clear register. A core's interrupt line stays high as long as any bit of its pending word is one. A typical use is a doorbell: core 0 sets a bit in core 1's word, and core 1 clears that bit once it has handled the event.

The top of the window holds twelve read-only identification bytes. Every access is a 32-bit word access with a single-cycle request strobe. Read data and an illegal-access flag come back from registers one cycle after the request. Accesses that break the register map produce a one-cycle illegal pulse and leave all state untouched.

Top module: `dbell_unit`

## Requirements
- R1: While reset is asserted and right after it, both pending words are zero, both interrupt outputs are low, read data is zero and the illegal flag is low.
- R2: A write to offset 0x004 (core 0) or 0x014 (core 1) ORs write data bits [3:0] into that core's pending word. Write data bits [31:4] are ignored.
- R3: A write to offset 0x008 (core 0) or 0x018 (core 1) clears every pending bit whose write data bit in [3:0] is one. Other bits keep their value.
- R4: A read of offset 0x000 (core 0) or 0x010 (core 1) returns that core's pending word in bits [3:0], with bits [31:4] zero.
- R5: Each interrupt output is high exactly when its core's pending word is nonzero. It takes its new value at the same clock edge that accepts the write.
- R6: Reads of word offsets 0xFD0 through 0xFFC return these values in bits [7:0], in ascending address order: 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Upper bits are zero.
- R7: Reads of the set and clear offsets, and reads of unmapped offsets, return zero.
- R8: Writes to the pending-word offsets, the identification offsets and unmapped offsets leave both pending words and both interrupt outputs unchanged.
- R9: The illegal flag is high for exactly one cycle after each of these requests: a read of a set or clear offset, a write to a pending-word or identification offset, or any access to an unmapped offset. An address with bits [1:0] not equal to zero counts as unmapped. The flag is low after every other request and after idle cycles.
- R10: Read data and the illegal flag are registered. Both are valid one cycle after the request strobe, and read data holds its value until the next read.
- R11: The two cores' pending words are independent: a set or clear aimed at one core never changes the other core's word or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Single-cycle access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_wdata | input | DATA_W | Write data, little-endian word |
| rsp_rdata | output | DATA_W | Registered read data |
| rsp_illegal | output | 1 | One-cycle illegal-access pulse |
| irq_core0 | output | 1 | Level interrupt to core 0 |
| irq_core1 | output | 1 | Level interrupt to core 1 |

## Verification
Every result of this block is due one clock edge after the edge that samples the request strobe. This holds for the pending word, both interrupt lines, read data and the illegal flag. The bench drives each request on a falling edge and checks all outputs on the next falling edge, before it drives the following request. Back-to-back requests therefore show that the illegal flag drops again after one cycle. Idle cycles show that read data holds.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

   localparam int CORES      = 2;
   localparam int ID_COUNT   = 12;
   localparam int ID_IDX_W   = 4;

   localparam logic [11:0] CORE_STRIDE = 12'h010;
   localparam logic [11:0] OFF_STAT    = 12'h000;
   localparam logic [11:0] OFF_SET     = 12'h004;
   localparam logic [11:0] OFF_CLR     = 12'h008;
   localparam logic [11:0] ID_BASE     = 12'hFD0;

   typedef enum logic [2:0] {
      K_NONE,
      K_STAT,
      K_SET,
      K_CLR,
      K_ID,
      K_BAD
   } kind_e;

   typedef struct packed {
      kind_e                kind;
      logic                 core;
      logic [ID_IDX_W-1:0]  id_idx;
   } dec_t;

   function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
      logic [7:0] v;
      case (idx)
         4'd0:    v = 8'h04;
         4'd4:    v = 8'h56;
         4'd5:    v = 8'hB8;
         4'd6:    v = 8'h0B;
         4'd8:    v = 8'h0D;
         4'd9:    v = 8'hF0;
         4'd10:   v = 8'h05;
         4'd11:   v = 8'hB1;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam logic [ADDR_W-1:0] ID_LO = ADDR_W'(ID_BASE);
   localparam logic [ADDR_W-1:0] ID_HI = ADDR_W'(12'hFFC);

   logic [ADDR_W-1:0] id_off;
   assign id_off = addr - ID_LO;

   always_comb begin
      dec        = '0;
      dec.kind   = K_BAD;
      if (addr[1:0] != 2'b00) begin
         dec.kind = K_BAD;
      end else if (addr >= ID_LO && addr <= ID_HI) begin
         dec.kind   = K_ID;
         dec.id_idx = id_off[ID_IDX_W+1:2];
      end else begin
         for (int c = 0; c < CORES; c++) begin
            if (addr == ADDR_W'(CORE_STRIDE * 12'(c) + OFF_STAT)) begin
               dec.kind = K_STAT;
               dec.core = c[0];
            end
            if (addr == ADDR_W'(CORE_STRIDE * 12'(c) + OFF_SET)) begin
               dec.kind = K_SET;
               dec.core = c[0];
            end
            if (addr == ADDR_W'(CORE_STRIDE * 12'(c) + OFF_CLR)) begin
               dec.kind = K_CLR;
               dec.core = c[0];
            end
         end
      end
   end

endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
   parameter int NUM_BITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_en,
   input  logic                clr_en,
   input  logic [NUM_BITS-1:0] bits,
   output logic [NUM_BITS-1:0] stat,
   output logic                irq
);

   logic [NUM_BITS-1:0] set_v;
   logic [NUM_BITS-1:0] clr_v;
   logic [NUM_BITS-1:0] nxt;

   always_comb begin
      set_v = set_en ? bits : '0;
      clr_v = clr_en ? bits : '0;
      nxt   = (stat | set_v) & ~clr_v;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
         irq  <= 1'b0;
      end else begin
         stat <= nxt;
         irq  <= |nxt;
      end
   end

endmodule

// File: rtl/dbell_unit.sv
module dbell_unit
   import dbell_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int NUM_BITS     = 4,
   parameter bit RD_IDLE_ZERO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_illegal,
   output logic              irq_core0,
   output logic              irq_core1
);

   if (ADDR_W < 12) begin : g_bad_addr
      $error("dbell_unit: ADDR_W must cover a 4 KB window");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("dbell_unit: DATA_W must hold an identification byte");
   end
   if (NUM_BITS < 1 || NUM_BITS > DATA_W) begin : g_bad_bits
      $error("dbell_unit: NUM_BITS out of range");
   end

   dec_t dec;
   logic rd_req;
   logic wr_req;
   logic [NUM_BITS-1:0] wbits;
   logic [NUM_BITS-1:0] core_stat [CORES];
   logic [CORES-1:0]    core_irq;

   assign rd_req = req_valid && !req_write;
   assign wr_req = req_valid &&  req_write;
   assign wbits  = req_wdata[NUM_BITS-1:0];

   dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (req_addr),
      .dec  (dec)
   );

   for (genvar c = 0; c < CORES; c++) begin : g_core
      logic hit;
      assign hit = (dec.core == c[0]);
      dbell_status #(.NUM_BITS(NUM_BITS)) u_stat (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (wr_req && dec.kind == K_SET && hit),
         .clr_en (wr_req && dec.kind == K_CLR && hit),
         .bits   (wbits),
         .stat   (core_stat[c]),
         .irq    (core_irq[c])
      );
   end

   assign irq_core0 = core_irq[0];
   assign irq_core1 = core_irq[1];

   logic [DATA_W-1:0] rd_val;
   logic              bad_acc;

   always_comb begin
      rd_val = '0;
      case (dec.kind)
         K_STAT:  rd_val = DATA_W'(core_stat[dec.core]);
         K_ID:    rd_val = DATA_W'(id_byte(dec.id_idx));
         default: rd_val = '0;
      endcase
   end

   always_comb begin
      bad_acc = 1'b0;
      if (rd_req)
         bad_acc = (dec.kind == K_SET) || (dec.kind == K_CLR) || (dec.kind == K_BAD);
      else if (wr_req)
         bad_acc = (dec.kind == K_STAT) || (dec.kind == K_ID) || (dec.kind == K_BAD);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_illegal <= 1'b0;
      else        rsp_illegal <= bad_acc;
   end

   if (RD_IDLE_ZERO) begin : g_rd_zero
      always_ff @(posedge clk) begin
         if (!rst_n)      rsp_rdata <= '0;
         else if (rd_req) rsp_rdata <= rd_val;
         else             rsp_rdata <= '0;
      end
   end else begin : g_rd_hold
      always_ff @(posedge clk) begin
         if (!rst_n)      rsp_rdata <= '0;
         else if (rd_req) rsp_rdata <= rd_val;
      end
   end

endmodule

// File: rtl/dbell_unit_chk.sv
module dbell_unit_chk #(
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int NUM_BITS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                req_write,
   input logic [ADDR_W-1:0]   req_addr,
   input logic [DATA_W-1:0]   req_wdata,
   input logic [DATA_W-1:0]   rsp_rdata,
   input logic                rsp_illegal,
   input logic                irq_core0,
   input logic                irq_core1,
   input logic [NUM_BITS-1:0] stat0,
   input logic [NUM_BITS-1:0] stat1
);

   // R5: each interrupt line follows its pending word
   a_r5_irq0_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_core0 == (stat0 != '0));
   a_r5_irq1_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_core1 == (stat1 != '0));

   // R2: set write leaves all masked bits high
   a_r2_set_core0: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(12'h004))
      |=> ((stat0 & $past(req_wdata[NUM_BITS-1:0])) == $past(req_wdata[NUM_BITS-1:0])));

   // R3: clear write leaves all masked bits low
   a_r3_clr_core0: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_W'(12'h008))
      |=> ((stat0 & $past(req_wdata[NUM_BITS-1:0])) == '0));

   // R7 and R9: read of a write-only offset
   a_r7_rd_set_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_W'(12'h004))
      |=> (rsp_rdata == '0 && rsp_illegal));

   // R9: no request, no illegal pulse
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_illegal);

   // R8: writes into the identification bank change nothing
   a_r8_id_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr >= ADDR_W'(12'hFD0))
      |=> ($stable(stat0) && $stable(stat1) && rsp_illegal));

   // R6: one identification value
   a_r6_pid0_value: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_W'(12'hFE0))
      |=> (rsp_rdata == DATA_W'(8'h56)));

   // R11: a write aimed at core 0 leaves core 1 alone
   a_r11_core1_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr < ADDR_W'(12'h010))
      |=> $stable(stat1));

endmodule

bind dbell_unit dbell_unit_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .NUM_BITS (NUM_BITS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .req_wdata   (req_wdata),
   .rsp_rdata   (rsp_rdata),
   .rsp_illegal (rsp_illegal),
   .irq_core0   (irq_core0),
   .irq_core1   (irq_core1),
   .stat0       (core_stat[0]),
   .stat1       (core_stat[1])
);

// File: tb/dbell_unit_tb_top.sv
module dbell_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_illegal;
   logic        irq_core0;
   logic        irq_core1;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   dbell_unit dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_rdata   (rsp_rdata),
      .rsp_illegal (rsp_illegal),
      .irq_core0   (irq_core0),
      .irq_core1   (irq_core1)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp_rd;
      logic        exp_ill;
      logic        exp_i0;
      logic        exp_i1;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h000, 32'h0,         32'h0,  1'b0, 1'b0, 1'b0, 4'd4},  // R4
      '{1'b1, 12'h004, 32'hFFFF_FFF5, 32'h0,  1'b0, 1'b1, 1'b0, 4'd2},  // R2
      '{1'b0, 12'h000, 32'h0,         32'h5,  1'b0, 1'b1, 1'b0, 4'd2},  // R2
      '{1'b0, 12'h010, 32'h0,         32'h0,  1'b0, 1'b1, 1'b0, 4'd11}, // R11
      '{1'b1, 12'h014, 32'h0000_0002, 32'h0,  1'b0, 1'b1, 1'b1, 4'd11}, // R11
      '{1'b1, 12'h008, 32'h0000_0004, 32'h0,  1'b0, 1'b1, 1'b1, 4'd3},  // R3
      '{1'b0, 12'h000, 32'h0,         32'h1,  1'b0, 1'b1, 1'b1, 4'd3},  // R3
      '{1'b1, 12'h008, 32'hFFFF_FFF1, 32'h0,  1'b0, 1'b0, 1'b1, 4'd5},  // R5
      '{1'b0, 12'h004, 32'h0,         32'h0,  1'b1, 1'b0, 1'b1, 4'd7},  // R7
      '{1'b0, 12'h018, 32'h0,         32'h0,  1'b1, 1'b0, 1'b1, 4'd7},  // R7
      '{1'b0, 12'h00C, 32'h0,         32'h0,  1'b1, 1'b0, 1'b1, 4'd7},  // R7
      '{1'b1, 12'h010, 32'h0000_000F, 32'h0,  1'b1, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b0, 12'h010, 32'h0,         32'h2,  1'b0, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b1, 12'hFE0, 32'h0000_000F, 32'h0,  1'b1, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b1, 12'h01C, 32'h0000_000F, 32'h0,  1'b1, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b0, 12'h000, 32'h0,         32'h0,  1'b0, 1'b0, 1'b1, 4'd8},  // R8
      '{1'b0, 12'h006, 32'h0,         32'h0,  1'b1, 1'b0, 1'b1, 4'd9},  // R9
      '{1'b0, 12'hFD0, 32'h0,         32'h04, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFE0, 32'h0,         32'h56, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFE4, 32'h0,         32'hB8, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFE8, 32'h0,         32'h0B, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFEC, 32'h0,         32'h00, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFF0, 32'h0,         32'h0D, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFF4, 32'h0,         32'hF0, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFF8, 32'h0,         32'h05, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b0, 12'hFFC, 32'h0,         32'hB1, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
      '{1'b1, 12'h014, 32'h0000_0008, 32'h0,  1'b0, 1'b0, 1'b1, 4'd2},  // R2
      '{1'b1, 12'h018, 32'h0000_000A, 32'h0,  1'b0, 1'b0, 1'b0, 4'd3}   // R3
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: outputs while reset is held
      check("R1", "rdata", rsp_rdata, 32'h0);
      check("R1", "illegal", {31'h0, rsp_illegal}, 32'h0);
      check("R1", "irq0", {31'h0, irq_core0}, 32'h0);
      check("R1", "irq1", {31'h0, irq_core1}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string tg;
         tg = $sformatf("R%0d[v%0d]", VECS[i].rq, i);
         req_valid = 1'b1;
         req_write = VECS[i].wr;
         req_addr  = VECS[i].addr;
         req_wdata = VECS[i].wdata;
         @(negedge clk);
         if (!VECS[i].wr) check(tg, "rdata", rsp_rdata, VECS[i].exp_rd);
         check(tg, "illegal", {31'h0, rsp_illegal}, {31'h0, VECS[i].exp_ill});
         check(tg, "irq0", {31'h0, irq_core0}, {31'h0, VECS[i].exp_i0});
         check(tg, "irq1", {31'h0, irq_core1}, {31'h0, VECS[i].exp_i1});
      end

      // R10: read data holds through idle cycles; R9: pulse lasts one cycle
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'hFFC;
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 12'h004;
      @(negedge clk);
      check("R10", "rdata held", rsp_rdata, 32'hB1);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h008;
      @(negedge clk);
      check("R9", "illegal on clear read", {31'h0, rsp_illegal}, 32'h1);
      check("R7", "clear read zero", rsp_rdata, 32'h0);
      req_valid = 1'b0;
      @(negedge clk);
      check("R9", "illegal after idle", {31'h0, rsp_illegal}, 32'h0);
      check("R10", "rdata held zero", rsp_rdata, 32'h0);

      // R1: reset in mid-run clears the pending words
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h004; req_wdata = 32'h3;
      @(negedge clk);
      req_addr = 12'h014; req_wdata = 32'h8;
      @(negedge clk);
      req_valid = 1'b0;
      check("R5", "irq0 set", {31'h0, irq_core0}, 32'h1);
      check("R5", "irq1 set", {31'h0, irq_core1}, 32'h1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R1", "irq0 after reset", {31'h0, irq_core0}, 32'h0);
      check("R1", "irq1 after reset", {31'h0, irq_core1}, 32'h0);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h010;
      @(negedge clk);
      req_valid = 1'b0;
      check("R1", "core1 word after reset", rsp_rdata, 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule